// File: doc/BRIEF.md
# UART Receive DMA Request and Error Interrupt Controller

This block sits next to a UART receive FIFO. It watches the FIFO occupancy, the writes and reads of entries, and the error flag that travels with each entry. When the occupancy reaches a programmable threshold and DMA is enabled, it raises a receive DMA request. The per-entry error flag is the OR of the parity, framing and break flags held with that entry.

An errored entry gates DMA requests off. Software must then drain the FIFO through programmed I/O, so that a DMA engine never moves an errored byte without inspection. The block keeps a count of errored entries still held in the FIFO. It raises an error interrupt when such an entry arrives while DMA is enabled. It drives a FIFO-error status bit for as long as the count is nonzero. When the last errored entry has been read out, requests are restored without any software action. FIFO contents below the threshold, called trailing bytes, never produce a request. Software removes them by programmed I/O.

Top module: `rx_dma_req_ctl`

## Requirements
- R1: With `dma_en`=1, no errored entry held, `trig`≠0 and `level`≥`trig` at a rising edge, `dma_req` is 1 after that edge.
- R2: If `trig`=0 or `level`<`trig` at a rising edge (trailing bytes), `dma_req` is 0 after that edge.
- R3: An errored write (`push`=1 with `push_err`=1) makes `dma_req` 0 after that edge. It stays 0 while any errored entry is held.
- R4: The errored-entry count rises by one on an errored write and falls by one on an errored read (`pop`=1 with `pop_err`=1). Both in one cycle leave it unchanged. Requests resume after the edge at which the count reaches zero, if R1 holds there.
- R5: An errored write with `dma_en`=1 sets `err_irq` after that edge. `irq_id` reads 2'b11 while `err_irq` is 1 and 2'b00 otherwise.
- R6: An errored write with `dma_en`=0 leaves `err_irq` at 0.
- R7: `fifo_err` is 1 exactly while the errored-entry count is nonzero, updated at the edge of the write or read.
- R8: `err_irq` clears after an edge with `lsr_rd`=1, or after the edge at which the count reaches zero. A new errored write with `dma_en`=1 at the same edge as `lsr_rd` keeps it set.
- R9: `fifo_reset`=1 zeroes the count, `fifo_err`, `err_irq` and `dma_req` after that edge, and a write in the same cycle is not counted. After reset, all outputs are 0.
- R10: With `dma_en`=0 at a rising edge, `dma_req` is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dma_en | input | 1 | Receive DMA requests enabled |
| trig | input | LW | Trigger threshold; 0 disables requests |
| level | input | LW | Current FIFO occupancy |
| push | input | 1 | Entry written into FIFO |
| push_err | input | 1 | Written entry carries an error flag |
| pop | input | 1 | Entry read from FIFO |
| pop_err | input | 1 | Read entry carries an error flag |
| fifo_reset | input | 1 | FIFO flush |
| lsr_rd | input | 1 | Line-status read strobe |
| dma_req | output | 1 | Receive DMA request |
| err_irq | output | 1 | Error interrupt |
| irq_id | output | 2 | Interrupt identification: 2'b11 error, 2'b00 none |
| fifo_err | output | 1 | Errored entry present in FIFO |

## Verification
Every output is registered. A stimulus applied in one cycle therefore appears on `dma_req`, `err_irq`, `irq_id` and `fifo_err` right after the next rising edge, and never later. The bench drives inputs on the falling edge and steps a reference model at the same time. It compares all four outputs on the following falling edge, one edge after the stimulus. Directed steps cover threshold equality, a zero threshold, count draining, a line-status read coinciding with a new error, and a flush coinciding with a write. Random steps mix these conditions.

// File: rtl/rx_dma_req_ctl.sv
module rx_dma_req_ctl #(
  parameter int DEPTH = 16,
  parameter int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dma_en,
  input  logic [LW-1:0] trig,
  input  logic [LW-1:0] level,
  input  logic          push,
  input  logic          push_err,
  input  logic          pop,
  input  logic          pop_err,
  input  logic          fifo_reset,
  input  logic          lsr_rd,
  output logic          dma_req,
  output logic          err_irq,
  output logic [1:0]    irq_id,
  output logic          fifo_err
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] err_cnt, err_cnt_nxt;
  logic err_in, err_out, irq_set, irq_clr, req_nxt;

  assign err_in  = push & push_err;
  assign err_out = pop & pop_err;

  always_comb begin
    err_cnt_nxt = err_cnt;
    if (fifo_reset)            err_cnt_nxt = '0;
    else if (err_in & !err_out) err_cnt_nxt = err_cnt + 1'b1;
    else if (!err_in & err_out) err_cnt_nxt = err_cnt - 1'b1;
  end

  assign irq_set = err_in & dma_en & !fifo_reset;
  assign irq_clr = lsr_rd | (err_cnt_nxt == '0);
  assign req_nxt = !fifo_reset && dma_en && (err_cnt_nxt == '0) &&
                   (trig != '0) && (level >= trig);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_cnt <= '0;
      err_irq <= 1'b0;
      dma_req <= 1'b0;
    end else begin
      err_cnt <= err_cnt_nxt;
      dma_req <= req_nxt;
      if (fifo_reset)   err_irq <= 1'b0;
      else if (irq_set) err_irq <= 1'b1;
      else if (irq_clr) err_irq <= 1'b0;
    end
  end

  assign fifo_err = (err_cnt != '0);
  assign irq_id   = err_irq ? 2'b11 : 2'b00;

  p_req_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> !fifo_err);
  p_trailing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (trig == '0 || level < trig) |=> !dma_req);
  p_irq_dma_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_irq) |-> $past(dma_en));
  p_irq_has_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> fifo_err);
  p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_reset |=> (!fifo_err && !err_irq && !dma_req));
  p_dma_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |=> !dma_req);
  p_err_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && push_err && !fifo_reset) |=> fifo_err);
endmodule

// File: tb/rx_dma_req_ctl_tb.sv
module rx_dma_req_ctl_tb;
  localparam int DEPTH = 16;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic dma_en = 0, push = 0, push_err = 0, pop = 0, pop_err = 0;
  logic fifo_reset = 0, lsr_rd = 0;
  logic [LW-1:0] trig = '0, level = '0;
  logic dma_req, err_irq, fifo_err;
  logic [1:0] irq_id;

  int checks = 0, fails = 0, cyc = 0;
  int m_cnt = 0;
  bit m_req = 0, m_irq = 0, done = 0;

  rx_dma_req_ctl #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .trig(trig), .level(level),
    .push(push), .push_err(push_err), .pop(pop), .pop_err(pop_err),
    .fifo_reset(fifo_reset), .lsr_rd(lsr_rd), .dma_req(dma_req),
    .err_irq(err_irq), .irq_id(irq_id), .fifo_err(fifo_err));

  always #5 clk = ~clk;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int next_cnt(int c, bit fr, bit pe, bit po);
    if (fr) return 0;
    return c + (pe ? 1 : 0) - (po ? 1 : 0);
  endfunction

  function automatic bit next_req(bit fr, bit en, int c, int t, int l);
    return !fr && en && c == 0 && t != 0 && l >= t;
  endfunction

  function automatic bit next_irq(bit cur, bit fr, bit pe, bit en, bit lr, int c);
    if (fr) return 0;
    if (pe && en) return 1;
    if (lr || c == 0) return 0;
    return cur;
  endfunction

  task automatic step(bit en, int t, int l, bit pu, bit pue, bit po, bit poe,
                      bit fr, bit lr, string tag);
    string rq, ri;
    bit pe, ope;
    dma_en = en; trig = LW'(t); level = LW'(l); push = pu; push_err = pue;
    pop = po; pop_err = poe; fifo_reset = fr; lsr_rd = lr;
    pe = pu && pue; ope = po && poe;
    m_irq = next_irq(m_irq, fr, pe, en, lr, next_cnt(m_cnt, fr, pe, ope));
    m_cnt = next_cnt(m_cnt, fr, pe, ope);
    m_req = next_req(fr, en, m_cnt, t, l);
    if (tag != "") begin rq = tag; ri = tag; end
    else begin
      if (fr) rq = "R9"; else if (!en) rq = "R10"; else if (m_cnt != 0) rq = "R3";
      else if (t == 0 || l < t) rq = "R2"; else rq = "R1";
      if (fr) ri = "R9"; else if (lr) ri = "R8"; else if (!en) ri = "R6"; else ri = "R5";
    end
    @(posedge clk); @(negedge clk);
    chk(rq, "dma_req", dma_req, m_req);
    chk(ri, "err_irq", err_irq, m_irq);
    chk("R5", "irq_id", irq_id, m_irq ? 3 : 0);
    chk("R7", "fifo_err", fifo_err, m_cnt != 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R9", "reset dma_req", dma_req, 0);
    chk("R9", "reset err_irq", err_irq, 0);
    chk("R9", "reset fifo_err", fifo_err, 0);
    rst_n = 1;
    @(negedge clk);
    // R1 threshold equal, R2 below and zero threshold
    step(1, 8, 8, 0,0,0,0, 0,0, "R1");
    step(1, 8, 7, 0,0,0,0, 0,0, "R2");
    step(1, 0, 8, 0,0,0,0, 0,0, "R2");
    step(1, 8, 9, 0,0,0,0, 0,0, "R1");
    // R3 / R5 errored write gates requests and raises interrupt
    step(1, 8, 10, 1,1,0,0, 0,0, "R3");
    step(1, 8, 11, 1,1,0,0, 0,0, "R4");
    step(1, 8, 11, 1,1,1,1, 0,0, "R4");
    step(1, 8, 10, 0,0,1,1, 0,0, "R4");
    step(1, 8, 9, 0,0,1,1, 0,0, "R4");
    // R8 lsr read together with new error keeps irq, alone clears it
    step(1, 8, 9, 1,1,0,0, 0,1, "R8");
    step(1, 8, 9, 0,0,0,0, 0,1, "R8");
    step(1, 8, 9, 0,0,0,0, 0,0, "R8");
    // R9 flush with a simultaneous errored write
    step(1, 8, 0, 1,1,0,0, 1,0, "R9");
    step(1, 8, 9, 0,0,0,0, 0,0, "R1");
    // R6 / R10 DMA disabled
    step(0, 8, 9, 1,1,0,0, 0,0, "R6");
    step(0, 8, 9, 0,0,0,0, 0,0, "R10");
    step(1, 8, 9, 0,0,1,1, 0,0, "R4");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      bit pue, poe, pu, po;
      pu = $urandom_range(0, 1); po = $urandom_range(0, 1);
      pue = (m_cnt < DEPTH - 1) && ($urandom_range(0, 3) == 0);
      poe = (m_cnt > 0) && ($urandom_range(0, 2) == 0);
      step($urandom_range(0, 5) != 0, $urandom_range(0, DEPTH),
           $urandom_range(0, DEPTH), pu, pue, po, poe,
           $urandom_range(0, 40) == 0, $urandom_range(0, 10) == 0, "");
    end
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule